// File: doc/BRIEF.md
# Five-Channel Compare Timer

This peripheral runs a free 32-bit timebase that advances once per clock and can be loaded through a word-wide register port. Five compare channels each hold a compare value and a compare mask. A channel matches while the masked timebase equals the masked compare value. Each rising edge of a match latches an event bit in a shared interrupt status register.

Each channel drives one output pin. While the pin is enabled, it shows a programmed level during a match and the inverse of that level otherwise. While it is disabled, it holds its last value. The status register has two offsets: one sets bits and one clears bits. Five interrupt lines show the status ANDed with a per-channel mask. Software reaches everything with 4-byte accesses at word-aligned offsets. Read data comes back one cycle after the request.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset every register reads zero, `pin_out` and `irq_out` are low, and a match that has held continuously since reset does not raise a status event.
- R2: The timebase (offset 0x00) increments by one every clock. A word write to 0x00 loads the written value. A read issued in the cycle right after the load returns that value, and a read one cycle later returns it plus one.
- R3: Output enable (0x10), output level (0x14), compare i (0x80+4i) and compare mask i (0xC0+4i) keep only bits 31:27. Channel i owns bit 31-i of the enable and level registers. Interrupt mask (0x18) and interrupt enable (0x24) keep only bits 15:11, and channel i owns bit 15-i. The status register never holds a bit outside 15:11.
- R4: Channel i matches when (timebase & mask_i) == (compare_i & mask_i). A rising edge of the match sets status bit 15-i on the same clock edge that registers the pin change. A match that stays high raises no further event after a clear.
- R5: A write to 0x1C ORs (data & 0x0000F800) into the status. A write to 0x20 clears every status bit that is 1 in (data & 0x0000F800). A read of either offset returns the status.
- R6: `irq_out[i]` equals status bit 15-i AND interrupt mask bit 15-i. It updates on the same clock edge as the register write or event that changes either bit. The interrupt enable register is stored and read back but does not gate `irq_out`.
- R7: While output enable bit 31-i is 1, `pin_out[i]` is registered from the match. The pin takes level bit 31-i on the edge after the timebase first matches and the inverted level on the edge after it stops matching.
- R8: While output enable bit 31-i is 0, `pin_out[i]` keeps its value whatever the timebase does.
- R9: When a clear write and a hardware match event hit the same status bit in the same cycle, the bit ends up set. The same holds for a set write meeting an event.
- R10: A read of an unmapped offset (for example 0x40 or 0x94) or of a non-word-aligned offset returns 0xFFFFFFFF.
- R11: An access with `req_bytes` other than 4 is not a register access. A write of that kind changes nothing, and a read of that kind returns 0xFFFFFFFF.
- R12: `rd_data` is registered. It changes only on the edge that samples a read request and holds between reads, including across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_bytes | input | 3 | Access size in bytes; only 4 is accepted |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| pin_out | output | 5 | Compare output pins, bit i = channel i |
| irq_out | output | 5 | Masked interrupt lines, bit i = channel i |

## Verification
A corrupted timebase shows up as a wrong read value two cycles after a load. It also moves the match edge, so a pin and its interrupt change one or more cycles early or late against a cycle-exact expectation. A lost or stuck match-edge register either drops the status event or repeats it after a clear. A single extra read of status exposes that. A wrong status or mask bit reaches `irq_out` on the very next edge, so interrupt lines are checked in the cycle after each write. Pin levels are compared on both sides of the match boundary, and once more after the enable is removed.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  localparam logic [7:0] OFS_TBASE  = 8'h00;
  localparam logic [7:0] OFS_OUT_EN = 8'h10;
  localparam logic [7:0] OFS_OUT_LV = 8'h14;
  localparam logic [7:0] OFS_IRQ_MK = 8'h18;
  localparam logic [7:0] OFS_ST_SET = 8'h1C;
  localparam logic [7:0] OFS_ST_CLR = 8'h20;
  localparam logic [7:0] OFS_IRQ_EN = 8'h24;
  localparam logic [7:0] OFS_CMP    = 8'h80;
  localparam logic [7:0] OFS_MSK    = 8'hC0;
  localparam int         MID_TOP    = 15;
  localparam logic [2:0] WORD_BYTES = 3'd4;
endpackage

// File: rtl/ctu_timebase.sv
module ctu_timebase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else           count <= count + DW'(1);
  end
endmodule

// File: rtl/ctu_channel.sv
module ctu_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] tbase,
  input  logic [DW-1:0] cmp_val,
  input  logic [DW-1:0] cmp_msk,
  input  logic          out_en,
  input  logic          out_lv,
  output logic          event_o,
  output logic          pin_o
);
  logic hit;
  logic hit_q;

  assign hit     = ((tbase ^ cmp_val) & cmp_msk) == '0;
  assign event_o = hit && !hit_q;

  // hit_q starts at 1 so a match that persists from reset is not an edge
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b1;
      pin_o <= 1'b0;
    end else begin
      hit_q <= hit;
      if (out_en) pin_o <= hit ? out_lv : !out_lv;
    end
  end
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import ctu_pkg::*;
#(
  parameter int NCH = 5,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [2:0]     req_bytes,
  input  logic [DW-1:0]  req_wdata,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] pin_out,
  output logic [NCH-1:0] irq_out
);
  localparam int HI_LSB  = DW - NCH;
  localparam int MID_LSB = MID_TOP + 1 - NCH;
  localparam logic [DW-1:0] FIELD    = DW'((1 << NCH) - 1);
  localparam logic [DW-1:0] HI_MASK  = FIELD << HI_LSB;
  localparam logic [DW-1:0] MID_MASK = FIELD << MID_LSB;

  function automatic logic at(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  logic          acc, wr, rd;
  logic          tb_ld;
  logic [DW-1:0] tb_q;
  logic [DW-1:0] oe_q, ol_q, im_q, ie_q, st_q;
  logic [DW-1:0] st_d, im_d, set_v, clr_v, hw_mid, rd_mux;
  logic [DW-1:0] cmp_q [NCH];
  logic [DW-1:0] msk_q [NCH];
  logic [NCH-1:0] oe_ch, ol_ch, ev, irq_d;

  assign acc   = req_valid && (req_bytes == WORD_BYTES) && (req_addr[1:0] == 2'b00);
  assign wr    = acc && req_write;
  assign rd    = acc && !req_write;
  assign tb_ld = wr && at(req_addr, OFS_TBASE);

  ctu_timebase #(.DW(DW)) u_tb (
    .clk(clk), .rst(rst), .load(tb_ld), .load_val(req_wdata), .count(tb_q)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_cmp, sel_msk;
    assign sel_cmp  = wr && (req_addr == AW'(OFS_CMP) + AW'(4 * i));
    assign sel_msk  = wr && (req_addr == AW'(OFS_MSK) + AW'(4 * i));
    assign oe_ch[i] = oe_q[DW-1-i];
    assign ol_ch[i] = ol_q[DW-1-i];

    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[i] <= '0;
        msk_q[i] <= '0;
      end else begin
        if (sel_cmp) cmp_q[i] <= req_wdata & HI_MASK;
        if (sel_msk) msk_q[i] <= req_wdata & HI_MASK;
      end
    end

    ctu_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .tbase(tb_q), .cmp_val(cmp_q[i]), .cmp_msk(msk_q[i]),
      .out_en(oe_ch[i]), .out_lv(ol_ch[i]), .event_o(ev[i]), .pin_o(pin_out[i])
    );

    assign irq_d[i] = st_d[MID_TOP-i] && im_d[MID_TOP-i];
  end

  always_comb begin
    hw_mid = '0;
    for (int i = 0; i < NCH; i++) hw_mid[MID_TOP-i] = ev[i];
  end

  assign set_v = (wr && at(req_addr, OFS_ST_SET)) ? (req_wdata & MID_MASK) : '0;
  assign clr_v = (wr && at(req_addr, OFS_ST_CLR)) ? (req_wdata & MID_MASK) : '0;
  assign st_d  = (st_q & ~clr_v) | set_v | hw_mid;
  assign im_d  = (wr && at(req_addr, OFS_IRQ_MK)) ? (req_wdata & MID_MASK) : im_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q    <= '0;
      ol_q    <= '0;
      im_q    <= '0;
      ie_q    <= '0;
      st_q    <= '0;
      irq_out <= '0;
    end else begin
      if (wr && at(req_addr, OFS_OUT_EN)) oe_q <= req_wdata & HI_MASK;
      if (wr && at(req_addr, OFS_OUT_LV)) ol_q <= req_wdata & HI_MASK;
      if (wr && at(req_addr, OFS_IRQ_EN)) ie_q <= req_wdata & MID_MASK;
      im_q    <= im_d;
      st_q    <= st_d;
      irq_out <= irq_d;
    end
  end

  always_comb begin
    rd_mux = '1;
    if (at(req_addr, OFS_TBASE))  rd_mux = tb_q;
    if (at(req_addr, OFS_OUT_EN)) rd_mux = oe_q;
    if (at(req_addr, OFS_OUT_LV)) rd_mux = ol_q;
    if (at(req_addr, OFS_IRQ_MK)) rd_mux = im_q;
    if (at(req_addr, OFS_ST_SET) || at(req_addr, OFS_ST_CLR)) rd_mux = st_q;
    if (at(req_addr, OFS_IRQ_EN)) rd_mux = ie_q;
    for (int i = 0; i < NCH; i++) begin
      if (req_addr == AW'(OFS_CMP) + AW'(4 * i)) rd_mux = cmp_q[i];
      if (req_addr == AW'(OFS_MSK) + AW'(4 * i)) rd_mux = msk_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   rd_data <= '0;
    else if (rd)               rd_data <= rd_mux;
    else if (req_valid && !req_write && !acc) rd_data <= '1;
  end
endmodule

// File: rtl/ctu_checker.sv
module ctu_checker #(
  parameter int NCH = 5,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic [DW-1:0]  tb,
  input logic           tb_ld,
  input logic [DW-1:0]  st,
  input logic [DW-1:0]  im,
  input logic [NCH-1:0] oe_ch,
  input logic [NCH-1:0] pin,
  input logic [NCH-1:0] irq
);
  localparam int MTOP = 15;
  localparam logic [DW-1:0] MID_MASK = DW'((1 << NCH) - 1) << (MTOP + 1 - NCH);

  p_tb_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tb_ld)) |-> tb == $past(tb) + DW'(1));

  p_status_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (st & ~MID_MASK) == '0);

  p_pin_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pin ^ $past(pin)) & ~$past(oe_ch)) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_irq
    p_irq_mask_r6: assert property (@(posedge clk) disable iff (rst)
      irq[i] == (st[MTOP-i] && im[MTOP-i]));
  end
endmodule

bind cmp_timer_unit ctu_checker #(.NCH(NCH), .DW(DW)) u_ctu_checker (
  .clk(clk), .rst(rst), .tb(tb_q), .tb_ld(tb_ld), .st(st_q), .im(im_q),
  .oe_ch(oe_ch), .pin(pin_out), .irq(irq_out)
);

// File: tb/test_cmp_timer_unit.sv
module test_cmp_timer_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr  = '0;
  logic [2:0]  req_bytes = 3'd4;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic [4:0]  pin_out, irq_out;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = !clk;

  cmp_timer_unit i_cmp_timer_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rd_data(rd_data), .pin_out(pin_out), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] b = 3'd4);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_bytes = b;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_bytes = 3'd4;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [2:0] b = 3'd4);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_bytes = b;
    @(negedge clk);
    d = rd_data;
    req_valid = 1'b0; req_bytes = 3'd4;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pins", {27'd0, pin_out}, 32'd0);
    chk("R1 irqs", {27'd0, irq_out}, 32'd0);
    rd(8'h10, d); chk("R1 out enable", d, 32'd0);
    rd(8'h1C, d); chk("R1 status no event from held match", d, 32'd0);
    rd(8'h84, d); chk("R1 compare", d, 32'd0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, d); chk("R3 out enable", d, 32'hF800_0000);
    wr(8'h10, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, d); chk("R3 irq mask", d, 32'h0000_F800);
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, d); chk("R3 irq enable", d, 32'h0000_F800);
    wr(8'h84, 32'hFFFF_FFFF); rd(8'h84, d); chk("R3 compare 1", d, 32'hF800_0000);
    wr(8'hC4, 32'hFFFF_FFFF); rd(8'hC4, d); chk("R3 mask 1", d, 32'hF800_0000);
    // R12: rd_data holds across a write
    wr(8'h18, 32'h0);
    chk("R12 read data held", rd_data, 32'hF800_0000);
  endtask

  task automatic t_tbase();
    logic [31:0] d;
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, d); chk("R2 load", d, 32'h1234_5678);
    rd(8'h00, d); chk("R2 increment", d, 32'h1234_5679);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(8'h40, d); chk("R10 hole", d, 32'hFFFF_FFFF);
    rd(8'h94, d); chk("R10 past last compare", d, 32'hFFFF_FFFF);
    rd(8'h12, d); chk("R10 misaligned", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(8'h18, 32'h0000_8000);
    wr(8'h18, 32'h0000_0000, 3'd1);
    rd(8'h18, d); chk("R11 byte write ignored", d, 32'h0000_8000);
    rd(8'h18, d, 3'd2); chk("R11 halfword read", d, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_C000);
    wr(8'h1C, 32'hFFFF_FFFF);
    chk("R6 irq after set", {27'd0, irq_out}, 32'h0000_0003);
    rd(8'h1C, d); chk("R5 set ORs masked", d, 32'h0000_F800);
    wr(8'h20, 32'h0000_4000);
    chk("R6 irq after clear", {27'd0, irq_out}, 32'h0000_0001);
    rd(8'h20, d); chk("R5 clear", d, 32'h0000_B800);
    wr(8'h24, 32'h0);
    chk("R6 enable does not gate", {27'd0, irq_out}, 32'h0000_0001);
    wr(8'h18, 32'h0);
    chk("R6 mask removed", {27'd0, irq_out}, 32'h0);
  endtask

  task automatic t_match();
    logic [31:0] d;
    wr(8'h80, 32'h0800_0000);
    wr(8'hC0, 32'hF800_0000);
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h8000_0000);
    wr(8'h20, 32'h0000_F800);
    wr(8'h18, 32'h0000_8000);
    chk("R7 inverse level before match", {31'd0, pin_out[0]}, 32'd1);
    wr(8'h00, 32'h07FF_FFFE);
    @(negedge clk);
    @(negedge clk);
    chk("R7 pin before match edge", {31'd0, pin_out[0]}, 32'd1);
    chk("R4 no irq before match", {31'd0, irq_out[0]}, 32'd0);
    @(negedge clk);
    chk("R7 pin at match", {31'd0, pin_out[0]}, 32'd0);
    chk("R4 irq at match", {31'd0, irq_out[0]}, 32'd1);
    rd(8'h1C, d); chk("R4 status bit 15", d, 32'h0000_8000);
    wr(8'h00, 32'h0);
    chk("R7 pin one edge after mismatch load", {31'd0, pin_out[0]}, 32'd0);
    @(negedge clk);
    chk("R7 pin inverse after mismatch", {31'd0, pin_out[0]}, 32'd1);
  endtask

  task automatic t_hold();
    wr(8'h10, 32'h0);
    wr(8'h00, 32'h07FF_FFFF);
    repeat (3) @(negedge clk);
    chk("R8 disabled pin holds", {31'd0, pin_out[0]}, 32'd1);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(8'h00, 32'h0);
    wr(8'h20, 32'h0000_F800);
    wr(8'h00, 32'h07FF_FFFE);
    @(negedge clk);
    @(negedge clk);
    wr(8'h20, 32'h0000_8000);
    rd(8'h20, d); chk("R9 event beats clear", d, 32'h0000_8000);
    wr(8'h20, 32'h0000_8000);
    rd(8'h20, d); chk("R4 held match gives no new event", d, 32'h0);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h07FF_FFFE);
    @(negedge clk);
    @(negedge clk);
    wr(8'h1C, 32'h0000_8000);
    rd(8'h1C, d); chk("R9 event with set", d, 32'h0000_8000);
    chk("R6 irq with event and set", {31'd0, irq_out[0]}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_tbase();
    t_unmapped();
    t_width();
    t_setclr();
    t_match();
    t_hold();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule